// File: doc/BRIEF.md
# Descriptor Bypass Beat Assembler

This block sits on the user side of a DMA engine's descriptor bypass output. The engine presents fetched descriptors one beat at a time on a valid/ready channel. Each beat has a 256-bit data bus and sideband fields: a size code, a stream-or-memory flag, queue, function and port identifiers, the ring consumer index, an error strobe and a format code. Descriptors of 8, 16 and 32 bytes arrive in one beat. A 64-byte descriptor arrives in two beats, low half first.

The assembler keeps the low half of a long descriptor in a holding register until the second beat arrives. It then builds one record of 512 data bits with its sideband fields and a byte count, and zeroes every byte past the valid payload. The payload length comes from the size code. In streaming mode the length is further capped by transfer direction: 16 bytes host-to-card, 8 bytes card-to-host. A reserved format code or an error strobe on either beat marks the record as errored, and the record is still forwarded so its ring index can be echoed back on the bypass-in path.

The record waits on the output until the consumer takes it. Input ready is withheld only while an unconsumed record is held and the consumer is not ready.

Top module: `descBeatAssembler`

## Requirements
- R1: The size code gives the payload length: code 0 = 8 bytes, 1 = 16, 2 = 32, 3 = 64. For a memory-mapped descriptor (mode flag 1), `outBytes` equals that length.
- R2: A size-3 descriptor is accepted as two handshakes. No record appears after the first beat. The first beat's data lands in `outDsc[255:0]` and the second beat's in `outDsc[511:256]`.
- R3: For a two-beat descriptor, size, mode flag, queue, function, port, format and consumer index are taken from the second beat only.
- R4: The 16-bit consumer index of the beat that completes a record appears unchanged on `outCidx`.
- R5: For a streaming descriptor (mode flag 0), the length is capped at 16 bytes when `C2H_DIR`=0 and at 8 bytes when `C2H_DIR`=1. Every `outDsc` byte at or above `outBytes` reads zero.
- R6: `outErr` is 1 when the completing beat has a format code of 1 to 7, or when the error input was high on either beat of the descriptor. The record is still presented.
- R7: While `outVld`=1 and `outRdy`=0, the record holds steady and `inRdy`=0, so no beat is taken.
- R8: Synchronous active-high reset clears output valid and the beat state. A descriptor that was half received is dropped, and the next beat starts a fresh descriptor.
- R9: Each accepted single-beat descriptor, and each completed two-beat descriptor, yields exactly one record. A record and a new beat can be exchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Beat valid |
| inRdy | output | 1 | Beat ready |
| inDsc | input | 256 | Beat data |
| inSize | input | 2 | Descriptor size code |
| inStMm | input | 1 | 0 streaming, 1 memory-mapped |
| inQid | input | 11 | Queue identifier |
| inErr | input | 1 | Fetch error strobe |
| inFunc | input | 8 | Function identifier |
| inCidx | input | 16 | Ring consumer index |
| inPort | input | 3 | Port identifier |
| inFmt | input | 3 | Format code, 0 standard |
| outVld | output | 1 | Record valid |
| outRdy | input | 1 | Record ready |
| outDsc | output | 512 | Assembled descriptor data, trimmed |
| outBytes | output | 7 | Valid payload bytes |
| outSize | output | 2 | Size code of the record |
| outStMm | output | 1 | Mode flag of the record |
| outQid | output | 11 | Queue identifier |
| outFunc | output | 8 | Function identifier |
| outCidx | output | 16 | Consumer index to echo |
| outPort | output | 3 | Port identifier |
| outFmt | output | 3 | Format code |
| outErr | output | 1 | Record error flag |

## Verification
Assertions run on every cycle and cover four things:
- the record stays steady and input is refused under backpressure;
- a reserved format always raises the error flag;
- the byte count is a power of two within the stream cap, and the trimmed tail is zero;
- a single-beat handshake always yields a record carrying its consumer index.

Only the bench scenarios can show the remaining behaviour: correct placement of the two halves, sideband taken from the second beat rather than the first, error stickiness across beats, and loss of a half-received descriptor on reset. The bench does this by sweeping every size, mode, format class and error position against arithmetic expectations.

// File: rtl/descBeatPkg.sv
package descBeatPkg;
  localparam logic [1:0] SIZE_LONG = 2'd3;

  typedef struct packed {
    logic loadLow;
    logic loadRec;
    logic secondBeat;
  } beatCtrlT;
endpackage

// File: rtl/descBeatCtrl.sv
module descBeatCtrl
  import descBeatPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inVld,
  input  logic [1:0] inSize,
  input  logic       outRdy,
  output logic       inRdy,
  output logic       outVld,
  output beatCtrlT   ctrl
);
  logic beatCnt;
  logic vldQ;
  logic accept;

  assign inRdy  = !vldQ || outRdy;
  assign accept = inVld && inRdy;
  assign outVld = vldQ;

  always_comb begin
    ctrl.loadLow    = accept && !beatCnt && (inSize == SIZE_LONG);
    ctrl.loadRec    = accept && !ctrl.loadLow;
    ctrl.secondBeat = beatCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beatCnt <= 1'b0;
      vldQ    <= 1'b0;
    end else begin
      if (ctrl.loadLow)      beatCnt <= 1'b1;
      else if (ctrl.loadRec) beatCnt <= 1'b0;
      if (ctrl.loadRec)      vldQ <= 1'b1;
      else if (outRdy)       vldQ <= 1'b0;
    end
  end
endmodule

// File: rtl/descBeatPath.sv
module descBeatPath
  import descBeatPkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int QID_W   = 11,
  parameter int FUNC_W  = 8,
  parameter int PORT_W  = 3,
  parameter int IDX_W   = 16,
  parameter int FMT_W   = 3,
  parameter bit C2H_DIR = 1'b0,
  localparam int REC_W    = 2 * DATA_W,
  localparam int REC_B    = REC_W / 8,
  localparam int CNT_W    = $clog2(REC_B) + 1,
  localparam int BASE_B   = DATA_W / 32,
  localparam int STREAM_B = C2H_DIR ? DATA_W / 32 : DATA_W / 16
) (
  input  logic              clk,
  input  logic              rst,
  input  beatCtrlT          ctrl,
  input  logic [DATA_W-1:0] inDsc,
  input  logic [1:0]        inSize,
  input  logic              inStMm,
  input  logic [QID_W-1:0]  inQid,
  input  logic              inErr,
  input  logic [FUNC_W-1:0] inFunc,
  input  logic [IDX_W-1:0]  inCidx,
  input  logic [PORT_W-1:0] inPort,
  input  logic [FMT_W-1:0]  inFmt,
  output logic [REC_W-1:0]  outDsc,
  output logic [CNT_W-1:0]  outBytes,
  output logic [1:0]        outSize,
  output logic              outStMm,
  output logic [QID_W-1:0]  outQid,
  output logic [FUNC_W-1:0] outFunc,
  output logic [IDX_W-1:0]  outCidx,
  output logic [PORT_W-1:0] outPort,
  output logic [FMT_W-1:0]  outFmt,
  output logic              outErr
);
  logic [DATA_W-1:0] lowReg;
  logic              lowErr;
  logic [REC_W-1:0]  fullData;
  logic [REC_W-1:0]  trimData;
  logic [CNT_W-1:0]  sizeBytes;
  logic [CNT_W-1:0]  keepBytes;
  logic              recErr;

  always_comb begin
    sizeBytes = CNT_W'(BASE_B) << inSize;
    if (!inStMm && sizeBytes > CNT_W'(STREAM_B)) keepBytes = CNT_W'(STREAM_B);
    else                                          keepBytes = sizeBytes;
    fullData = ctrl.secondBeat ? {inDsc, lowReg} : {{DATA_W{1'b0}}, inDsc};
    recErr   = inErr || (inFmt != '0) || (ctrl.secondBeat && lowErr);
  end

  for (genvar g = 0; g < REC_B; g++) begin : g_trim
    assign trimData[g*8 +: 8] = (CNT_W'(g) < keepBytes) ? fullData[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lowReg <= '0;
      lowErr <= 1'b0;
    end else if (ctrl.loadLow) begin
      lowReg <= inDsc;
      lowErr <= inErr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outDsc   <= '0;
      outBytes <= '0;
      outSize  <= '0;
      outStMm  <= 1'b0;
      outQid   <= '0;
      outFunc  <= '0;
      outCidx  <= '0;
      outPort  <= '0;
      outFmt   <= '0;
      outErr   <= 1'b0;
    end else if (ctrl.loadRec) begin
      outDsc   <= trimData;
      outBytes <= keepBytes;
      outSize  <= inSize;
      outStMm  <= inStMm;
      outQid   <= inQid;
      outFunc  <= inFunc;
      outCidx  <= inCidx;
      outPort  <= inPort;
      outFmt   <= inFmt;
      outErr   <= recErr;
    end
  end
endmodule

// File: rtl/descBeatAssembler.sv
module descBeatAssembler
  import descBeatPkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int QID_W   = 11,
  parameter int FUNC_W  = 8,
  parameter int PORT_W  = 3,
  parameter int IDX_W   = 16,
  parameter int FMT_W   = 3,
  parameter bit C2H_DIR = 1'b0,
  localparam int REC_W  = 2 * DATA_W,
  localparam int CNT_W  = $clog2(REC_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inVld,
  output logic              inRdy,
  input  logic [DATA_W-1:0] inDsc,
  input  logic [1:0]        inSize,
  input  logic              inStMm,
  input  logic [QID_W-1:0]  inQid,
  input  logic              inErr,
  input  logic [FUNC_W-1:0] inFunc,
  input  logic [IDX_W-1:0]  inCidx,
  input  logic [PORT_W-1:0] inPort,
  input  logic [FMT_W-1:0]  inFmt,
  output logic              outVld,
  input  logic              outRdy,
  output logic [REC_W-1:0]  outDsc,
  output logic [CNT_W-1:0]  outBytes,
  output logic [1:0]        outSize,
  output logic              outStMm,
  output logic [QID_W-1:0]  outQid,
  output logic [FUNC_W-1:0] outFunc,
  output logic [IDX_W-1:0]  outCidx,
  output logic [PORT_W-1:0] outPort,
  output logic [FMT_W-1:0]  outFmt,
  output logic              outErr
);
  beatCtrlT ctrl;

  descBeatCtrl i_ctrl (
    .clk(clk), .rst(rst), .inVld(inVld), .inSize(inSize), .outRdy(outRdy),
    .inRdy(inRdy), .outVld(outVld), .ctrl(ctrl)
  );

  descBeatPath #(
    .DATA_W(DATA_W), .QID_W(QID_W), .FUNC_W(FUNC_W), .PORT_W(PORT_W),
    .IDX_W(IDX_W), .FMT_W(FMT_W), .C2H_DIR(C2H_DIR)
  ) i_path (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .inDsc(inDsc), .inSize(inSize), .inStMm(inStMm), .inQid(inQid),
    .inErr(inErr), .inFunc(inFunc), .inCidx(inCidx), .inPort(inPort),
    .inFmt(inFmt),
    .outDsc(outDsc), .outBytes(outBytes), .outSize(outSize), .outStMm(outStMm),
    .outQid(outQid), .outFunc(outFunc), .outCidx(outCidx), .outPort(outPort),
    .outFmt(outFmt), .outErr(outErr)
  );
endmodule

// File: rtl/descBeatChecker.sv
module descBeatChecker #(
  parameter int DATA_W  = 256,
  parameter int IDX_W   = 16,
  parameter int FMT_W   = 3,
  parameter bit C2H_DIR = 1'b0,
  localparam int REC_W    = 2 * DATA_W,
  localparam int REC_B    = REC_W / 8,
  localparam int CNT_W    = $clog2(REC_B) + 1,
  localparam int STREAM_B = C2H_DIR ? DATA_W / 32 : DATA_W / 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inVld,
  input logic             inRdy,
  input logic [1:0]       inSize,
  input logic [IDX_W-1:0] inCidx,
  input logic             outVld,
  input logic             outRdy,
  input logic [REC_W-1:0] outDsc,
  input logic [CNT_W-1:0] outBytes,
  input logic             outStMm,
  input logic [FMT_W-1:0] outFmt,
  input logic             outErr,
  input logic [IDX_W-1:0] outCidx
);
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!outVld && inRdy));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (outVld && !outRdy) |=> (outVld && $stable(outDsc) && $stable(outCidx) && $stable(outBytes)));

  assert_no_take_R7: assert property (@(posedge clk) disable iff (rst)
    (outVld && !outRdy) |-> !inRdy);

  assert_cidx_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (inVld && inRdy && inSize != 2'd3) |=> (outVld && outCidx == $past(inCidx)));

  assert_fmt_err_R6: assert property (@(posedge clk) disable iff (rst)
    (outVld && outFmt != '0) |-> outErr);

  assert_len_code_R1: assert property (@(posedge clk) disable iff (rst)
    outVld |-> ($countones(outBytes) == 1 && outBytes <= CNT_W'(REC_B)));

  assert_stream_cap_R5: assert property (@(posedge clk) disable iff (rst)
    (outVld && !outStMm) |-> (outBytes <= CNT_W'(STREAM_B)));

  assert_zero_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (outVld && outBytes < CNT_W'(REC_B)) |-> ((outDsc >> {outBytes, 3'b000}) == '0));
endmodule

bind descBeatAssembler descBeatChecker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .FMT_W(FMT_W), .C2H_DIR(C2H_DIR)
) i_chk (
  .clk(clk), .rst(rst), .inVld(inVld), .inRdy(inRdy), .inSize(inSize),
  .inCidx(inCidx), .outVld(outVld), .outRdy(outRdy), .outDsc(outDsc),
  .outBytes(outBytes), .outStMm(outStMm), .outFmt(outFmt), .outErr(outErr),
  .outCidx(outCidx)
);

// File: tb/test_descBeatAssembler.sv
`timescale 1ns/1ps
module test_descBeatAssembler;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inVld = 1'b0;
  logic [255:0] inDsc = '0;
  logic [1:0]   inSize = '0;
  logic         inStMm = 1'b0;
  logic [10:0]  inQid = '0;
  logic         inErr = 1'b0;
  logic [7:0]   inFunc = '0;
  logic [15:0]  inCidx = '0;
  logic [2:0]   inPort = '0;
  logic [2:0]   inFmt = '0;
  logic         outRdy = 1'b1;

  logic         inRdy, outVld, outStMm, outErr;
  logic [511:0] outDsc;
  logic [6:0]   outBytes;
  logic [1:0]   outSize;
  logic [10:0]  outQid;
  logic [7:0]   outFunc;
  logic [15:0]  outCidx;
  logic [2:0]   outPort, outFmt;

  logic         cInRdy, cOutVld, cOutStMm, cOutErr;
  logic [511:0] cOutDsc;
  logic [6:0]   cOutBytes;
  logic [1:0]   cOutSize;
  logic [10:0]  cOutQid;
  logic [7:0]   cOutFunc;
  logic [15:0]  cOutCidx;
  logic [2:0]   cOutPort, cOutFmt;

  int passCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  descBeatAssembler #(.C2H_DIR(1'b0)) i_descBeatAssembler (
    .clk(clk), .rst(rst), .inVld(inVld), .inRdy(inRdy), .inDsc(inDsc),
    .inSize(inSize), .inStMm(inStMm), .inQid(inQid), .inErr(inErr),
    .inFunc(inFunc), .inCidx(inCidx), .inPort(inPort), .inFmt(inFmt),
    .outVld(outVld), .outRdy(outRdy), .outDsc(outDsc), .outBytes(outBytes),
    .outSize(outSize), .outStMm(outStMm), .outQid(outQid), .outFunc(outFunc),
    .outCidx(outCidx), .outPort(outPort), .outFmt(outFmt), .outErr(outErr)
  );

  descBeatAssembler #(.C2H_DIR(1'b1)) i_c2h (
    .clk(clk), .rst(rst), .inVld(inVld), .inRdy(cInRdy), .inDsc(inDsc),
    .inSize(inSize), .inStMm(inStMm), .inQid(inQid), .inErr(inErr),
    .inFunc(inFunc), .inCidx(inCidx), .inPort(inPort), .inFmt(inFmt),
    .outVld(cOutVld), .outRdy(outRdy), .outDsc(cOutDsc), .outBytes(cOutBytes),
    .outSize(cOutSize), .outStMm(cOutStMm), .outQid(cOutQid), .outFunc(cOutFunc),
    .outCidx(cOutCidx), .outPort(cOutPort), .outFmt(cOutFmt), .outErr(cOutErr)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] trim(input logic [511:0] d, input int nBytes);
    logic [511:0] r = '0;
    for (int b = 0; b < 64; b++)
      if (b < nBytes) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [255:0] pattern(input int n, input logic [31:0] seed);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = seed ^ (32'(n) << 8) ^ 32'(i * 17 + 1);
    return r;
  endfunction

  task automatic setBeat(input logic [1:0] sz, input logic mm, input logic [255:0] d,
                         input logic [15:0] cx, input logic [10:0] q, input logic [7:0] fn,
                         input logic [2:0] pt, input logic e, input logic [2:0] fm);
    inSize = sz; inStMm = mm; inDsc = d; inCidx = cx; inQid = q;
    inFunc = fn; inPort = pt; inErr = e; inFmt = fm;
  endtask

  // Drive from a falling edge; holds until a rising edge sees ready.
  task automatic pushBeat();
    bit ok;
    inVld = 1'b1;
    while (1) begin
      ok = inRdy;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    inVld = 1'b0;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(outVld == 1'b0, "R8 reset outVld", 512'(outVld), 0);
    chk(inRdy == 1'b1, "R8 reset inRdy", 512'(inRdy), 1);

    // Sweep size, mode, format class, error; outRdy held high.
    for (int sz = 0; sz < 4; sz++)
      for (int mm = 0; mm < 2; mm++)
        for (int f = 0; f < 2; f++)
          for (int e = 0; e < 2; e++) begin
            logic [255:0] lo, hi;
            logic [511:0] full, expH, expC;
            logic [15:0] cx;
            logic [2:0] fm;
            int nb, capH, capC;
            n++;
            lo = pattern(n, 32'hC0DE0000);
            hi = pattern(n, 32'h5EED0000);
            cx = 16'h0100 + 16'(n);
            fm = f ? 3'd5 : 3'd0;
            nb = 8 << sz;
            capH = (!mm && nb > 16) ? 16 : nb;
            capC = (!mm && nb > 8) ? 8 : nb;
            if (sz == 3) begin
              // R3: decoy sideband on the first beat; error (if any) only on first beat.
              setBeat(2'd3, ~1'(mm), lo, ~cx, 11'h7AA, 8'hEE, 3'd6, 1'(e), 3'd0);
              pushBeat();
              chk(outVld == 1'b0, "R2 no record after first beat", 512'(outVld), 0);
              setBeat(2'd3, 1'(mm), hi, cx, 11'(n), 8'(n + 3), 3'(n), 1'b0, fm);
              pushBeat();
              full = {hi, lo};
            end else begin
              setBeat(2'(sz), 1'(mm), lo, cx, 11'(n), 8'(n + 3), 3'(n), 1'(e), fm);
              pushBeat();
              full = {256'h0, lo};
            end
            expH = trim(full, capH);
            expC = trim(full, capC);
            chk(outVld == 1'b1, "R9 record present", 512'(outVld), 1);
            chk(outBytes == 7'(capH), mm ? "R1 length" : "R5 stream length", 512'(outBytes), 512'(capH));
            chk(outDsc == expH, sz == 3 ? "R2 beat order" : "R5 trimmed data", outDsc, expH);
            chk(cOutBytes == 7'(capC), "R5 c2h length", 512'(cOutBytes), 512'(capC));
            chk(cOutDsc == expC, "R5 c2h trimmed data", cOutDsc, expC);
            chk(outCidx == cx, "R4 consumer index", 512'(outCidx), 512'(cx));
            chk(outQid == 11'(n) && outFunc == 8'(n + 3) && outPort == 3'(n),
                "R3 ids", {outQid, outFunc, outPort}, {11'(n), 8'(n + 3), 3'(n)});
            chk(outStMm == 1'(mm) && outSize == 2'(sz) && outFmt == fm,
                "R3 mode size fmt", {outStMm, outSize, outFmt}, {1'(mm), 2'(sz), fm});
            chk(outErr == 1'(e | f), "R6 error flag", 512'(outErr), 512'(e | f));
          end

    // R7 / R9: backpressure, then simultaneous exchange.
    @(negedge clk);
    outRdy = 1'b0;
    setBeat(2'd0, 1'b1, pattern(90, 32'h11110000), 16'hAAAA, 11'd1, 8'd1, 3'd1, 1'b0, 3'd0);
    pushBeat();
    chk(outVld == 1'b1 && outCidx == 16'hAAAA, "R7 first record held", 512'(outCidx), 512'(16'hAAAA));
    setBeat(2'd1, 1'b1, pattern(91, 32'h22220000), 16'hBBBB, 11'd2, 8'd2, 3'd2, 1'b0, 3'd0);
    inVld = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(inRdy == 1'b0, "R7 input refused", 512'(inRdy), 0);
      chk(outCidx == 16'hAAAA && outVld == 1'b1, "R7 record stable", 512'(outCidx), 512'(16'hAAAA));
    end
    outRdy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inVld = 1'b0;
    chk(outVld == 1'b1 && outCidx == 16'hBBBB, "R9 exchange same cycle", 512'(outCidx), 512'(16'hBBBB));
    @(posedge clk);
    @(negedge clk);
    chk(outVld == 1'b0, "R9 single record", 512'(outVld), 0);

    // R8: reset in the middle of a long descriptor.
    setBeat(2'd3, 1'b1, pattern(92, 32'h33330000), 16'h1111, 11'd3, 8'd3, 3'd3, 1'b1, 3'd0);
    pushBeat();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(outVld == 1'b0 && inRdy == 1'b1, "R8 mid reset idle", {outVld, inRdy}, 2'b01);
    setBeat(2'd1, 1'b1, pattern(93, 32'h44440000), 16'h2222, 11'd4, 8'd4, 3'd4, 1'b0, 3'd0);
    pushBeat();
    begin
      logic [511:0] e8 = trim({256'h0, pattern(93, 32'h44440000)}, 16);
      chk(outDsc == e8, "R8 fresh descriptor data", outDsc, e8);
      chk(outBytes == 7'd16 && outErr == 1'b0, "R8 fresh length and no stale error",
          {outBytes, outErr}, {7'd16, 1'b0});
    end
    @(posedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule